// File: doc/BRIEF.md
# Outstanding Read-Miss Tracker

This block keeps track of cache-miss requests that are waiting on a disk access. It holds one entry per waiting requester. It makes sure that several reads to the same logical block cause only one physical read. The first reader of a block owns the physical read and becomes the active entry. Readers that arrive later attach as static entries. When the physical read returns, every waiter of that block is notified. Notifications leave one per cycle, and waiters are served in the order they arrived.

A write miss may arrive for a block whose physical read is still outstanding. The write's data supersedes the disk copy, so every waiter of that block is notified at once. The active entry is then kept as a marker with a discard flag. When the old physical read returns, it clears the marker silently and produces no notification. While such a marker exists, new reads to that block are held off. This prevents a second physical read from being confused with the stale one. Data storage, eviction and flushing belong to neighbouring blocks.

Top module: `pend_miss_table`

## Requirements
- R1: A read miss to a block with no outstanding physical read is accepted as the active entry. In the cycle after acceptance, phyReqValid is high for one cycle and phyReqAddr holds the block address.
- R2: A read miss to a block that already has an outstanding physical read is accepted as a static entry and issues no physical read. There is never more than one outstanding active entry per block.
- R3: When phyDoneValid is high for a block with an outstanding read, every waiter of that block is notified. The first notification appears in the cycle after the return, then one per consecutive cycle, oldest request first.
- R4: A write miss to a block with an outstanding read notifies every waiter of that block, active and static, starting the cycle after the write is accepted. The write itself produces no notification and no physical read.
- R5: The physical read superseded by such a write returns without producing any notification. Its marker is then freed, and a later read to that block issues a fresh physical read.
- R6: While a superseded read is still outstanding for a block, a read miss to that block sees missReady low.
- R7: With all DEPTH entries occupied (16 by default), read misses see missReady low. Write misses are still accepted.
- R8: A write miss to a block with no waiting entries has no effect: no notification and no physical read.
- R9: After reset the table is empty: cmplValid and phyReqValid are low and missReady is high.
- R10: Each notification carries the requester's tag on cmplTag and the block address on cmplAddr.
- R11: A read miss accepted in the same cycle as the physical read return for its block is notified along with that block's other waiters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Miss request present |
| missReady | output | 1 | Miss request accepted this cycle when high with missValid |
| missWrite | input | 1 | 1 = write miss, 0 = read miss |
| missAddr | input | AW (16) | Logical block address of the miss |
| missTag | input | TW (8) | Requester tag |
| phyReqValid | output | 1 | One-cycle physical read request |
| phyReqAddr | output | AW (16) | Block address of the physical read |
| phyDoneValid | input | 1 | Physical read return |
| phyDoneAddr | input | AW (16) | Block address of the returning read |
| cmplValid | output | 1 | Requester notification |
| cmplTag | output | TW (8) | Tag of the notified requester |
| cmplAddr | output | AW (16) | Block address of the notification |

## Verification
Suppose the active/static flag of an entry is wrong. A merged read would then show up at the ports as an extra phyReqValid pulse one cycle after acceptance. Alternatively, a first read would wait forever with no physical request. A lost drain mark shows as a missing notification once the expected burst has passed, and these bursts end within a few cycles of the return or write. A discard flag that is dropped or left stuck has two possible effects. The stale return may produce a spurious notification in the next cycle. Otherwise, missReady stays low for that block after the return should have freed it. If compaction breaks arrival order, it shows directly as a swapped tag sequence on cmplTag.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  // strobes from control to the entry store, one cycle each
  typedef struct packed {
    logic alloc;        // write a new entry
    logic allocActive;  // new entry owns the physical read
    logic allocDrain;   // new entry is notified immediately (joins a returning block)
    logic wrHit;        // write miss accepted
    logic pop;          // retire the entry selected by popIdx
  } tblCmd_t;
endpackage

// File: rtl/pmt_table.sv
module pmt_table
  import pmt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 16,
  parameter int TW    = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tblCmd_t                  cmd,
  input  logic [$clog2(DEPTH)-1:0] popIdx,
  input  logic [AW-1:0]            missAddr,
  input  logic [TW-1:0]            missTag,
  input  logic                     phyDoneValid,
  input  logic [AW-1:0]            phyDoneAddr,
  output logic                     outstHit,
  output logic                     discardHit,
  output logic                     phyLiveHit,
  output logic                     full,
  output logic [DEPTH-1:0]         drainVec,
  output logic [TW-1:0]            headTag,
  output logic [AW-1:0]            headAddr
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;

  // entries are kept compacted: lower index = older request
  logic [DEPTH-1:0]         vld, act, drn, dis;
  logic [DEPTH-1:0][AW-1:0] addrQ;
  logic [DEPTH-1:0][TW-1:0] tagQ;

  logic [DEPTH-1:0]         nVld, nAct, nDrn, nDis;
  logic [DEPTH-1:0][AW-1:0] nAddr;
  logic [DEPTH-1:0][TW-1:0] nTag;

  logic [DEPTH-1:0] mMiss, mPhy, outst;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mMiss[i] = vld[i] && (addrQ[i] == missAddr);
      mPhy[i]  = vld[i] && phyDoneValid && (addrQ[i] == phyDoneAddr);
      outst[i] = vld[i] && act[i] && !drn[i] && !dis[i];
    end
  end

  assign outstHit   = |(outst & mMiss);
  assign discardHit = |(dis & mMiss);
  assign phyLiveHit = |(outst & mPhy);
  assign full       = vld[DEPTH-1];
  assign drainVec   = vld & drn;
  assign headTag    = tagQ[popIdx];
  assign headAddr   = addrQ[popIdx];

  always_comb begin
    logic [CW-1:0] pos;
    pos   = '0;
    nVld  = '0;
    nAct  = '0;
    nDrn  = '0;
    nDis  = '0;
    nAddr = addrQ;
    nTag  = tagQ;
    for (int i = 0; i < DEPTH; i++) begin
      logic d, s, keep;
      d    = drn[i];
      s    = dis[i];
      keep = vld[i];
      // disk return releases all live waiters of the block
      if (phyLiveHit && mPhy[i] && !dis[i]) d = 1'b1;
      // write supersedes: release waiters, mark the outstanding read stale
      if (cmd.wrHit && mMiss[i] && !dis[i]) begin
        d = 1'b1;
        if (outst[i] && !mPhy[i]) s = 1'b1;
      end
      // stale return: drop marker, or cancel discard if still notifying
      if (mPhy[i] && dis[i]) begin
        if (drn[i]) s = 1'b0;
        else        keep = 1'b0;
      end
      // notification retires entry; a stale-pending one stays as a marker
      if (cmd.pop && (popIdx == IW'(i))) begin
        if (s) d = 1'b0;
        else   keep = 1'b0;
      end
      if (keep) begin
        nVld[pos[IW-1:0]]  = 1'b1;
        nAct[pos[IW-1:0]]  = act[i];
        nDrn[pos[IW-1:0]]  = d;
        nDis[pos[IW-1:0]]  = s;
        nAddr[pos[IW-1:0]] = addrQ[i];
        nTag[pos[IW-1:0]]  = tagQ[i];
        pos = pos + 1'b1;
      end
    end
    if (cmd.alloc) begin
      nVld[pos[IW-1:0]]  = 1'b1;
      nAct[pos[IW-1:0]]  = cmd.allocActive;
      nDrn[pos[IW-1:0]]  = cmd.allocDrain;
      nDis[pos[IW-1:0]]  = 1'b0;
      nAddr[pos[IW-1:0]] = missAddr;
      nTag[pos[IW-1:0]]  = missTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld <= '0;
      act <= '0;
      drn <= '0;
      dis <= '0;
    end else begin
      vld <= nVld;
      act <= nAct;
      drn <= nDrn;
      dis <= nDis;
    end
  end

  always_ff @(posedge clk) begin
    addrQ <= nAddr;
    tagQ  <= nTag;
  end

  // R2: never two outstanding reads for one block
  p_single_active_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(outst & mMiss) <= 1);

  // R7: control never allocates into a full store
  p_alloc_room_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.alloc |-> !full);
endmodule

// File: rtl/pmt_ctrl.sv
module pmt_ctrl
  import pmt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     missValid,
  input  logic                     missWrite,
  input  logic [AW-1:0]            missAddr,
  input  logic                     phyDoneValid,
  input  logic [AW-1:0]            phyDoneAddr,
  input  logic                     outstHit,
  input  logic                     discardHit,
  input  logic                     phyLiveHit,
  input  logic                     full,
  input  logic [DEPTH-1:0]         drainVec,
  output logic                     missReady,
  output logic                     phyReqValid,
  output logic [AW-1:0]            phyReqAddr,
  output logic                     cmplValid,
  output tblCmd_t                  cmd,
  output logic [$clog2(DEPTH)-1:0] popIdx
);
  localparam int IW = $clog2(DEPTH);

  logic accept;

  // writes never allocate, so they pass even when full
  assign missReady = missWrite || (!full && !discardHit);
  assign accept    = missValid && missReady;

  always_comb begin
    cmd             = '0;
    cmd.alloc       = accept && !missWrite;
    cmd.allocActive = !outstHit;
    cmd.allocDrain  = outstHit && phyLiveHit && phyDoneValid && (phyDoneAddr == missAddr);
    cmd.wrHit       = accept && missWrite;
    cmd.pop         = |drainVec;
  end

  // oldest draining entry first
  always_comb begin
    popIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (drainVec[i]) popIdx = IW'(i);
    end
  end

  assign cmplValid = |drainVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyReqValid <= 1'b0;
      phyReqAddr  <= '0;
    end else begin
      phyReqValid <= cmd.alloc && cmd.allocActive;
      phyReqAddr  <= missAddr;
    end
  end

  // R2: a merged read causes no physical request
  p_no_req_on_merge_r2: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missReady && !missWrite && outstHit) |=> !phyReqValid);

  // R6: reads to a block with a stale read in flight are held off
  p_stale_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && !missWrite && discardHit) |-> !missReady);
endmodule

// File: rtl/pend_miss_table.sv
module pend_miss_table
  import pmt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 16,
  parameter int TW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          missValid,
  output logic          missReady,
  input  logic          missWrite,
  input  logic [AW-1:0] missAddr,
  input  logic [TW-1:0] missTag,
  output logic          phyReqValid,
  output logic [AW-1:0] phyReqAddr,
  input  logic          phyDoneValid,
  input  logic [AW-1:0] phyDoneAddr,
  output logic          cmplValid,
  output logic [TW-1:0] cmplTag,
  output logic [AW-1:0] cmplAddr
);
  localparam int IW = $clog2(DEPTH);

  tblCmd_t          cmd;
  logic [IW-1:0]    popIdx;
  logic             outstHit, discardHit, phyLiveHit, full;
  logic [DEPTH-1:0] drainVec;

  pmt_ctrl #(.DEPTH(DEPTH), .AW(AW)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missWrite(missWrite), .missAddr(missAddr),
    .phyDoneValid(phyDoneValid), .phyDoneAddr(phyDoneAddr),
    .outstHit(outstHit), .discardHit(discardHit), .phyLiveHit(phyLiveHit),
    .full(full), .drainVec(drainVec),
    .missReady(missReady), .phyReqValid(phyReqValid), .phyReqAddr(phyReqAddr),
    .cmplValid(cmplValid), .cmd(cmd), .popIdx(popIdx)
  );

  pmt_table #(.DEPTH(DEPTH), .AW(AW), .TW(TW)) table_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .popIdx(popIdx),
    .missAddr(missAddr), .missTag(missTag),
    .phyDoneValid(phyDoneValid), .phyDoneAddr(phyDoneAddr),
    .outstHit(outstHit), .discardHit(discardHit), .phyLiveHit(phyLiveHit),
    .full(full), .drainVec(drainVec),
    .headTag(cmplTag), .headAddr(cmplAddr)
  );
endmodule

// File: tb/pend_miss_table_tb_top.sv
module pend_miss_table_tb_top;
  localparam int DEPTH = 16;
  localparam int AW    = 16;
  localparam int TW    = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          missValid = 1'b0;
  logic          missReady;
  logic          missWrite = 1'b0;
  logic [AW-1:0] missAddr = '0;
  logic [TW-1:0] missTag = '0;
  logic          phyReqValid;
  logic [AW-1:0] phyReqAddr;
  logic          phyDoneValid = 1'b0;
  logic [AW-1:0] phyDoneAddr = '0;
  logic          cmplValid;
  logic [TW-1:0] cmplTag;
  logic [AW-1:0] cmplAddr;

  pend_miss_table #(.DEPTH(DEPTH), .AW(AW), .TW(TW)) dut_i (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missReady(missReady), .missWrite(missWrite),
    .missAddr(missAddr), .missTag(missTag),
    .phyReqValid(phyReqValid), .phyReqAddr(phyReqAddr),
    .phyDoneValid(phyDoneValid), .phyDoneAddr(phyDoneAddr),
    .cmplValid(cmplValid), .cmplTag(cmplTag), .cmplAddr(cmplAddr)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // output logs, filled away from the active edge
  int nCmpl = 0;
  int nPhy = 0;
  int cmplTagLog [256];
  int cmplAddrLog[256];
  int cmplCycLog [256];
  int phyAddrLog [256];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN && cmplValid && nCmpl < 256) begin
      cmplTagLog[nCmpl]  = int'(cmplTag);
      cmplAddrLog[nCmpl] = int'(cmplAddr);
      cmplCycLog[nCmpl]  = cyc;
      nCmpl = nCmpl + 1;
    end
    if (rstN && phyReqValid && nPhy < 256) begin
      phyAddrLog[nPhy] = int'(phyReqAddr);
      nPhy = nPhy + 1;
    end
  end

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendMiss(input int a, input bit w, input int t);
    @(negedge clk);
    missValid = 1'b1;
    missWrite = w;
    missAddr  = AW'(a);
    missTag   = TW'(t);
    #1;
    while (!missReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    missValid = 1'b0;
    missWrite = 1'b0;
  endtask

  task automatic phyReturn(input int a);
    @(negedge clk);
    phyDoneValid = 1'b1;
    phyDoneAddr  = AW'(a);
    @(posedge clk);
    #1;
    phyDoneValid = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    checkEq("R9", "cmplValid after reset", int'(cmplValid), 0);
    checkEq("R9", "phyReqValid after reset", int'(phyReqValid), 0);
    checkEq("R9", "missReady after reset", int'(missReady), 1);
  endtask

  // R1 R2 R3 R10: merge of three readers, burst in arrival order
  task automatic testMergeAndReturn();
    int c0, p0;
    c0 = nCmpl; p0 = nPhy;
    sendMiss('h10, 1'b0, 1);
    sendMiss('h10, 1'b0, 2);
    sendMiss('h10, 1'b0, 3);
    idle(3);
    checkEq("R2", "physical reads for merged block", nPhy - p0, 1);
    checkEq("R1", "physical read address", phyAddrLog[p0], 'h10);
    checkEq("R3", "no notification before return", nCmpl - c0, 0);
    phyReturn('h10);
    idle(6);
    checkEq("R3", "notifications after return", nCmpl - c0, 3);
    for (int k = 0; k < 3; k++) begin
      checkEq("R3", "arrival order tag", cmplTagLog[c0 + k], k + 1);
      checkEq("R10", "notification address", cmplAddrLog[c0 + k], 'h10);
    end
    checkEq("R3", "consecutive cycle 2", cmplCycLog[c0 + 1] - cmplCycLog[c0], 1);
    checkEq("R3", "consecutive cycle 3", cmplCycLog[c0 + 2] - cmplCycLog[c0 + 1], 1);
  endtask

  // R4 R5 R6: write supersedes an outstanding read
  task automatic testWriteSupersede();
    int c0, p0, c1;
    c0 = nCmpl; p0 = nPhy;
    sendMiss('h20, 1'b0, 4);
    sendMiss('h20, 1'b0, 5);
    sendMiss('h20, 1'b1, 9);
    idle(5);
    checkEq("R4", "waiters released by write", nCmpl - c0, 2);
    checkEq("R4", "first released tag", cmplTagLog[c0], 4);
    checkEq("R4", "second released tag", cmplTagLog[c0 + 1], 5);
    checkEq("R4", "physical reads for block", nPhy - p0, 1);
    // R6: read to the block is held off while the stale read is in flight
    @(negedge clk);
    missValid = 1'b1; missWrite = 1'b0; missAddr = AW'('h20); missTag = TW'(7);
    #1;
    checkEq("R6", "missReady during stale read", int'(missReady), 0);
    @(negedge clk);
    #1;
    checkEq("R6", "missReady still low", int'(missReady), 0);
    missValid = 1'b0;
    c1 = nCmpl;
    phyReturn('h20);
    idle(5);
    checkEq("R5", "stale return notifications", nCmpl - c1, 0);
    sendMiss('h20, 1'b0, 6);
    idle(2);
    checkEq("R5", "fresh physical read after stale return", nPhy - p0, 2);
    checkEq("R5", "fresh physical read address", phyAddrLog[p0 + 1], 'h20);
    phyReturn('h20);
    idle(4);
    checkEq("R5", "fresh read notifications", nCmpl - c1, 1);
    checkEq("R5", "fresh read tag", cmplTagLog[c1], 6);
  endtask

  // R8: write with nothing waiting
  task automatic testLoneWrite();
    int c0, p0;
    c0 = nCmpl; p0 = nPhy;
    sendMiss('h30, 1'b1, 11);
    idle(4);
    checkEq("R8", "notifications from lone write", nCmpl - c0, 0);
    checkEq("R8", "physical reads from lone write", nPhy - p0, 0);
  endtask

  // R7: full table
  task automatic testFull();
    int c0, p0, c1;
    c0 = nCmpl; p0 = nPhy;
    for (int i = 0; i < DEPTH; i++) sendMiss('h40 + i, 1'b0, 16 + i);
    idle(2);
    checkEq("R7", "physical reads while filling", nPhy - p0, DEPTH);
    @(negedge clk);
    missValid = 1'b1; missWrite = 1'b0; missAddr = AW'('h60); missTag = TW'(60);
    #1;
    checkEq("R7", "read missReady when full", int'(missReady), 0);
    missWrite = 1'b1; missAddr = AW'('h40); missTag = TW'(61);
    #1;
    checkEq("R7", "write missReady when full", int'(missReady), 1);
    @(posedge clk);
    #1;
    missValid = 1'b0; missWrite = 1'b0;
    idle(3);
    checkEq("R7", "notifications from write when full", nCmpl - c0, 1);
    checkEq("R7", "tag released by write", cmplTagLog[c0], 16);
    c1 = nCmpl;
    for (int i = 0; i < DEPTH; i++) phyReturn('h40 + i);
    idle(4);
    checkEq("R3", "notifications after returns", nCmpl - c1, DEPTH - 1);
    for (int k = 0; k < DEPTH - 1; k++)
      checkEq("R3", "return order tag", cmplTagLog[c1 + k], 17 + k);
    @(negedge clk);
    missValid = 1'b1; missWrite = 1'b0; missAddr = AW'('h60); missTag = TW'(60);
    #1;
    checkEq("R7", "read missReady after drain", int'(missReady), 1);
    missValid = 1'b0;
  endtask

  // R11: read accepted in the cycle its block returns
  task automatic testSameCycleJoin();
    int c0, p0;
    c0 = nCmpl; p0 = nPhy;
    sendMiss('h70, 1'b0, 40);
    idle(1);
    @(negedge clk);
    missValid = 1'b1; missWrite = 1'b0; missAddr = AW'('h70); missTag = TW'(41);
    phyDoneValid = 1'b1; phyDoneAddr = AW'('h70);
    @(posedge clk);
    #1;
    missValid = 1'b0; phyDoneValid = 1'b0;
    idle(5);
    checkEq("R11", "notifications for joined block", nCmpl - c0, 2);
    checkEq("R11", "first tag", cmplTagLog[c0], 40);
    checkEq("R11", "joined tag", cmplTagLog[c0 + 1], 41);
    checkEq("R11", "physical reads", nPhy - p0, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMergeAndReturn();
    testWriteSupersede();
    testLoneWrite();
    testFull();
    testSameCycleJoin();
    idle(2);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule